// File: doc/BRIEF.md
# Segmented Carry-Prediction Approximate Adder

This block adds two unsigned operands approximately, trading accuracy for a short critical path. The sum is cut into a chain of independent exact sub-adders. No carry passes from one sub-adder to the next. Each sub-adder reaches a few bits further down into lower-order operand bits and guesses its own carry-in from them. The low "prediction" sum bits are then thrown away, and only the sub-adder's own result bits are kept. The longest carry path is therefore the widest sub-adder, not the full operand width.

The segment layout is fixed at elaboration by two parameter arrays. One array gives the result bits of each sub-adder and the other gives its prediction bits. The result bits must add up to the operand width. Each prediction depth must be smaller than the previous segment's prediction depth plus its result bits. A layout that breaks either rule stops elaboration with an error. Operands of unequal width are zero-extended to the wider one. The approximate sum is one bit wider than that and is registered once, with a synchronous active-high reset, so that it can sit in a timing-closed pipeline.

Top module: `qad_approx_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_o` becomes all zeros after that edge, whatever the operands are.
- R2: `sum_o` changes only at a rising edge. After each edge it shows the result for the operands present just before that edge, so there is one cycle of latency.
- R3: Sub-adder i exactly adds, with no carry-in, the operand bits from index L_i to index L_i+R_i+P_i−1 of both inputs. Here L_i = (R_0+…+R_i) + P_0 − R_i − P_i. Operand bits at index N or above are read as zero.
- R4: Output bits (R_0+…+R_(i−1)) to (R_0+…+R_i)−1 carry sum bits P_i through P_i+R_i−1 of sub-adder i. Sub-adder 0 fills the least significant end. With the default layout R=[4,2,2], P=[0,2,2]: 0xFF+0xFF gives 0x1FE, 0x30+0x10 gives 0x040, 0x0C+0x04 gives 0x010, and 0xFF+0x01 gives 0x0F0.
- R5: Output bit N is the carry-out of the last sub-adder. The carry-outs of the other sub-adders are discarded. With the default layout, 0x0F+0x01 gives 0x000, 0x3F+0x01 gives 0x030, and 0x80+0x80 gives 0x100.
- R6: A single segment with R=[N], P=[0] produces the exact (N+1)-bit sum for every operand pair.
- R7: With operand widths of 5 and 3 bits, both operands are zero-extended to 5 bits and `sum_o` is 6 bits wide.
- R8: For the default 8-bit layout, the largest absolute error against the exact sum over all 65536 operand pairs is 64. The summed absolute error is 491520, which is a mean of 7.5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a_i | input | A_WIDTH | First unsigned operand |
| op_b_i | input | B_WIDTH | Second unsigned operand |
| sum_o | output | max(A_WIDTH,B_WIDTH)+1 | Registered approximate sum |

## Verification
The only state in this block is the output register. Any wrong internal value therefore shows up at `sum_o` exactly one edge after the operands that cause it, and it stays confined to the output slice of one segment. A misplaced window offset, a wrong prediction depth or a swapped slice corrupts particular bit ranges for particular carry patterns. For this reason the default layout is swept over every operand pair and compared against an independent model of the window rule. The exhaustive error statistics catch faults that only bias the result. The exact single-segment and mixed-width instances show whether the chain itself, or the zero extension, has broken.

// File: rtl/qad_pkg.sv
package qad_pkg;

  // Upper bound on the number of segments a layout may use.
  localparam int MAX_SEGS = 8;

  // Per-segment configuration vector (unused tail entries stay zero).
  typedef int seg_vec_t [MAX_SEGS];

  // Sum of result widths of segments 0..upto inclusive.
  function automatic int cum_res(seg_vec_t res, int upto);
    int acc;
    acc = 0;
    for (int k = 0; k < MAX_SEGS; k++) begin
      if (k <= upto) acc += res[k];
    end
    return acc;
  endfunction

  // Lowest operand index read by segment idx.
  function automatic int win_lo(seg_vec_t res, seg_vec_t pred, int idx);
    return cum_res(res, idx) + pred[0] - res[idx] - pred[idx];
  endfunction

  // Layout legality: count in range, positive result widths, non-negative
  // prediction depths, result widths covering the operand, chain rule.
  function automatic bit cfg_ok(seg_vec_t res, seg_vec_t pred, int cnt, int width);
    bit ok;
    ok = (cnt >= 1) && (cnt <= MAX_SEGS);
    for (int k = 0; k < MAX_SEGS; k++) begin
      if (k < cnt) begin
        if (res[k] < 1 || pred[k] < 0) ok = 1'b0;
        if (k > 0 && !(pred[k] < pred[k-1] + res[k-1])) ok = 1'b0;
      end
    end
    if (ok && cum_res(res, cnt - 1) != width) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/qad_seg_adder.sv
// Exact ripple adder for one segment. Sum bits below DROP_LO are never
// formed (only their carries are), and the final carry is built only when
// KEEP_CARRY is set, so nothing unused is synthesised.
module qad_seg_adder #(
  parameter int WIDTH      = 4,
  parameter int DROP_LO    = 0,
  parameter bit KEEP_CARRY = 1'b0,
  localparam int OUT_W     = WIDTH - DROP_LO + int'(KEEP_CARRY)
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [OUT_W-1:0] res_o
);

  // c[j] is the carry into bit j; bit 0 has no carry-in.
  logic [WIDTH-1:0] c;
  assign c[0] = 1'b0;

  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    if (j >= DROP_LO) begin : g_sum
      assign res_o[j-DROP_LO] = x_i[j] ^ y_i[j] ^ c[j];
    end
    if (j < WIDTH - 1) begin : g_carry
      assign c[j+1] = (x_i[j] & y_i[j]) | (c[j] & (x_i[j] ^ y_i[j]));
    end else if (KEEP_CARRY) begin : g_cout
      assign res_o[OUT_W-1] = (x_i[j] & y_i[j]) | (c[j] & (x_i[j] ^ y_i[j]));
    end
  end

  // The ripple chain must agree with an arithmetic sum of the window.
  always_comb begin
    AST_SEG_SUM: assert (res_o == OUT_W'(({1'b0, x_i} + {1'b0, y_i}) >> DROP_LO))
      else $error("segment ripple sum disagrees with window sum"); // R3
  end

endmodule

// File: rtl/qad_sum_reg.sv
// Output register with synchronous active-high reset.
module qad_sum_reg #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/qad_approx_adder.sv
module qad_approx_adder #(
  parameter int A_WIDTH = 8,
  parameter int B_WIDTH = 8,
  parameter int SEG_CNT = 3,
  parameter qad_pkg::seg_vec_t RES_BITS  = '{4, 2, 2, 0, 0, 0, 0, 0},
  parameter qad_pkg::seg_vec_t PRED_BITS = '{0, 2, 2, 0, 0, 0, 0, 0},
  localparam int N = (A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [A_WIDTH-1:0] op_a_i,
  input  logic [B_WIDTH-1:0] op_b_i,
  output logic [N:0]         sum_o
);

  // Highest index any window reads is N+P0-1; pad up to there with zeros.
  localparam int PAD_W = N + PRED_BITS[0];
  localparam int LOW_W = RES_BITS[0];

  if (!qad_pkg::cfg_ok(RES_BITS, PRED_BITS, SEG_CNT, N)) begin : g_cfg_bad
    $error("segment layout violates width or prediction-chain rule");
  end

  logic [N-1:0]     a_ext;
  logic [N-1:0]     b_ext;
  logic [PAD_W-1:0] a_pad;
  logic [PAD_W-1:0] b_pad;
  wire  [N:0]       sum_d;

  assign a_ext = N'(op_a_i);
  assign b_ext = N'(op_b_i);
  assign a_pad = PAD_W'(a_ext);
  assign b_pad = PAD_W'(b_ext);

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
    localparam int  RW   = RES_BITS[g];
    localparam int  PW   = PRED_BITS[g];
    localparam int  WW   = RW + PW;
    localparam int  LO   = qad_pkg::win_lo(RES_BITS, PRED_BITS, g);
    localparam int  OFF  = qad_pkg::cum_res(RES_BITS, g) - RW;
    localparam bit  LAST = (g == SEG_CNT - 1);
    localparam int  OW   = RW + int'(LAST);

    logic [OW-1:0] seg_res;

    qad_seg_adder #(
      .WIDTH     (WW),
      .DROP_LO   (PW),
      .KEEP_CARRY(LAST)
    ) u_add (
      .x_i  (a_pad[LO +: WW]),
      .y_i  (b_pad[LO +: WW]),
      .res_o(seg_res)
    );

    assign sum_d[OFF +: OW] = seg_res;
  end

  qad_sum_reg #(
    .WIDTH(N + 1)
  ) u_reg (
    .clk(clk),
    .rst(rst),
    .d_i(sum_d),
    .q_o(sum_o)
  );

  // Reset clears the registered sum.
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_o == '0)); // R1

  if (PRED_BITS[0] == 0) begin : g_low_chk
    // The lowest segment sees every bit below it, so its slice is exact.
    AST_LOW_SEG_EXACT: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (sum_o[LOW_W-1:0] == $past(a_ext[LOW_W-1:0] + b_ext[LOW_W-1:0]))); // R4
    // With one operand zero no carry exists anywhere, so nothing is lost.
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(b_ext) == '0) |-> (sum_o == {1'b0, $past(a_ext)})); // R5
  end

  if (SEG_CNT == 1 && PRED_BITS[0] == 0) begin : g_exact_chk
    AST_SINGLE_SEG_EXACT: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (sum_o == $past({1'b0, a_ext} + {1'b0, b_ext}))); // R6
  end

endmodule

// File: tb/qad_approx_adder_tb_top.sv
`timescale 1ns/1ps
module qad_approx_adder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // Default layout under test
  logic [7:0] a8, b8;
  logic [8:0] s8;
  // Single exact segment, N=4
  logic [3:0] ea, eb;
  logic [4:0] es;
  // Unequal widths 5 and 3, single segment
  logic [4:0] ma;
  logic [2:0] mb;
  logic [5:0] ms;

  qad_approx_adder dut_i (
    .clk(clk), .rst(rst), .op_a_i(a8), .op_b_i(b8), .sum_o(s8)
  );

  qad_approx_adder #(
    .A_WIDTH(4), .B_WIDTH(4), .SEG_CNT(1),
    .RES_BITS('{4, 0, 0, 0, 0, 0, 0, 0}),
    .PRED_BITS('{0, 0, 0, 0, 0, 0, 0, 0})
  ) exact_i (
    .clk(clk), .rst(rst), .op_a_i(ea), .op_b_i(eb), .sum_o(es)
  );

  qad_approx_adder #(
    .A_WIDTH(5), .B_WIDTH(3), .SEG_CNT(1),
    .RES_BITS('{5, 0, 0, 0, 0, 0, 0, 0}),
    .PRED_BITS('{0, 0, 0, 0, 0, 0, 0, 0})
  ) mixed_i (
    .clk(clk), .rst(rst), .op_a_i(ma), .op_b_i(mb), .sum_o(ms)
  );

  localparam int RV [3] = '{4, 2, 2};
  localparam int PV [3] = '{0, 2, 2};

  // {a, b, expected sum} for the default layout
  localparam logic [24:0] VEC [7] = '{
    {8'hFF, 8'hFF, 9'h1FE},
    {8'h30, 8'h10, 9'h040},
    {8'h0C, 8'h04, 9'h010},
    {8'hFF, 8'h01, 9'h0F0},
    {8'h0F, 8'h01, 9'h000},
    {8'h3F, 8'h01, 9'h030},
    {8'h80, 8'h80, 9'h100}
  };

  // Behavioural model of the window rule for the default layout.
  function automatic int unsigned model(int unsigned a, int unsigned b);
    int unsigned res = 0;
    int cum = 0;
    for (int i = 0; i < 3; i++) begin
      int lo, w;
      int unsigned xa, xb, s;
      cum += RV[i];
      lo = cum + PV[0] - RV[i] - PV[i];
      w  = RV[i] + PV[i];
      xa = (a >> lo) & ((1 << w) - 1);
      xb = (b >> lo) & ((1 << w) - 1);
      s  = xa + xb;
      res |= ((s >> PV[i]) & ((1 << RV[i]) - 1)) << (cum - RV[i]);
      if (i == 2) res |= ((s >> w) & 1) << 8;
    end
    return res;
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int unsigned max_err = 0;
    int unsigned tot_err = 0;

    // R1: reset with non-zero operands
    a8 = 8'hFF; b8 = 8'hFF; ea = 4'hF; eb = 4'hF; ma = 5'h1F; mb = 3'h7;
    repeat (3) @(negedge clk);
    check("R1 reset default", s8, 0);
    check("R1 reset exact", es, 0);
    check("R1 reset mixed", ms, 0);
    rst = 1'b0;

    // R2: output holds until the next edge, then follows
    @(negedge clk);
    a8 = 8'h12; b8 = 8'h21;
    @(negedge clk);
    a8 = 8'h01; b8 = 8'h01;
    #1 check("R2 hold before edge", s8, 9'h033);
    @(negedge clk);
    check("R2 update after edge", s8, 9'h002);

    // Directed table: R3 windows, R4 assembly, R5 dropped carries
    foreach (VEC[k]) begin
      @(negedge clk);
      a8 = VEC[k][24:17];
      b8 = VEC[k][16:9];
      @(negedge clk);
      check((k >= 4) ? "R5 carry drop" : "R4 R3 table", s8, VEC[k][8:0]);
    end

    // Exhaustive sweep: R3/R4 against model, R6 exact, R7 mixed widths
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int unsigned got, ex, d;
        @(negedge clk);
        a8 = 8'(a); b8 = 8'(b);
        ea = 4'(a); eb = 4'(b);
        ma = 5'(a); mb = 3'(b);
        @(negedge clk);
        got = s8;
        check("R3 R4 sweep vs model", got, model(a, b));
        check("R6 exact single segment", es, (a % 16) + (b % 16));
        check("R7 mixed width", ms, (a % 32) + (b % 8));
        ex = a + b;
        d  = (got > ex) ? got - ex : ex - got;
        if (d > max_err) max_err = d;
        tot_err += d;
      end
    end
    check("R8 max abs error", max_err, 64);
    check("R8 total abs error", tot_err, 491520);

    // R1 again: reset mid-run
    @(negedge clk);
    a8 = 8'hAA; b8 = 8'h55; rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", s8, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after reset release", s8, model(8'hAA, 8'h55));

    finish_run();
  end

endmodule